// File: doc/BRIEF.md
# Configurable Crosspoint I/O Cell Fabric

This block is a small signal-routing fabric for board-level interconnect inside a chip. Every pin has an input stage and an output cell. The input stage optionally captures the pin. Its result joins a shared routing pool, which every output cell can read. The pins are split evenly into four groups. Each output cell holds a 4:1 multiplexer. Leg 0 may only take a pool signal from the first group, leg 1 only from the second, and so on. Two pool signals choose the leg at run time.

Four neighbouring cells form a quad. One cell of a quad can be set to cascade mode. It then uses two further pool signals to choose which quad member's 4:1 result it drives, which gives a 16:1 multiplexer with no extra register stage.

Each cell has a static configuration word. It sets:
- the pin index per leg
- the select pins
- the capture mode for the input side and for the output side: pass-through, transparent latch, or edge register
- the clock-strobe source and the enable source
- the enable pin and its polarity
- an optional forced constant

The whole fabric runs on one system clock. The clock sources are strobes, and the fabric captures on a rising edge it detects in one of them. Configuration words go into a shadow store through a write port. They become active together on a commit pulse. Until the first commit, every output is disabled.

Top module: `xp_crosspoint`

## Requirements
- R1: After reset, and until the first commit, every bit of `pin_oe` and `pin_out` is 0.
- R2: A write of `cfg_wdata` to cell `cfg_addr` only changes the shadow store. Outputs change only after the clock edge that samples `cfg_commit` high, which copies the whole shadow store (as it stood before that edge) into the active set.
- R3: In cell i, leg k (k = 0..3) reads pool pin `k*GS + leg_idx[k]`, where GS = pins/4. The leg driven is `{pool[sel_pin[1]], pool[sel_pin[0]]}`.
- R4: When `cascade` is 1 in a cell, its data is the 4:1 result of the member `{pool[sel_pin[3]], pool[sel_pin[2]]}` of its aligned quad (cells 4q..4q+3), with no added clock cycle.
- R5: Capture mode 0 (pass-through) routes a pin change to `pin_out` within the same cycle.
- R6: Capture mode 1 (latch) follows the data while the selected enable is 1. It holds the last value while the enable is 0.
- R7: Capture mode 2 (register) loads the data at the clock edge that sees a rising edge on the selected strobe, and only if the selected enable is 1. It holds otherwise.
- R8: The strobe source code `clk_src` 0..3 picks `gclk[clk_src]`, and 4 picks `pin_in[clk_pin]`. The enable code `ce_src` 0..3 picks `gce[ce_src]`, 4 picks `pin_in[ce_pin]`, and 5 means always enabled.
- R9: Input-side capture (`in_mode`, same encodings, using the pin's own cell strobe and enable) applies to the pin's value as seen in the pool.
- R10: `pin_oe[i]` is 1 when the cell's enable pin equals `oe_act_high`, so active-high when that bit is 1 and active-low when it is 0.
- R11: `force_val` 2 drives `pin_out` to 1 and 1 drives it to 0, whatever the multiplexer carries. 0 leaves the data path in control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Value seen on each pin |
| gclk | input | 4 | Global clock strobes |
| gce | input | 4 | Global clock enables |
| cfg_we | input | 1 | Shadow write strobe |
| cfg_addr | input | 4 | Cell index for the write |
| cfg_wdata | input | 50 | Packed configuration word |
| cfg_commit | input | 1 | Copy the shadow store into the active set |
| pin_out | output | 16 | Data each pin drives |
| pin_oe | output | 16 | Output enable for each pin |

## Verification
One strobe can drive both an input-side register and the output register that reads it. Both then capture at the same edge. The bench provokes this by putting the input stage of pin 1 and the output side of cell 5 on the same global strobe. It then pulses that strobe twice after changing pin 1. It judges that the first pulse delivers only the value captured before, and that the new pin level reaches `pin_out[5]` on the second pulse.

A second collision is a commit that lands on the same edge as a capture. The bench keeps these apart and checks each one's timing on its own.

// File: rtl/xp_pkg.sv
package xp_pkg;

    parameter int NPINS  = 16;
    parameter int NGRP   = 4;
    parameter int NGCLK  = 4;
    localparam int GSIZE = NPINS / NGRP;
    localparam int PW    = $clog2(NPINS);
    localparam int GW    = $clog2(GSIZE);
    localparam int KW    = $clog2(NGRP);
    localparam int QUAD  = 4;

    typedef enum logic [1:0] {
        CAP_COMB  = 2'd0,
        CAP_LATCH = 2'd1,
        CAP_REG   = 2'd2
    } cap_mode_e;

    typedef enum logic [1:0] {
        FRC_NONE = 2'd0,
        FRC_LOW  = 2'd1,
        FRC_HIGH = 2'd2
    } force_e;

    localparam logic [2:0] SRC_PIN = 3'd4;
    localparam logic [2:0] SRC_ONE = 3'd5;

    typedef struct packed {
        logic [NGRP-1:0][GW-1:0] leg_idx;
        logic [3:0][PW-1:0]      sel_pin;
        cap_mode_e               in_mode;
        cap_mode_e               out_mode;
        logic [2:0]              clk_src;
        logic [PW-1:0]           clk_pin;
        logic [2:0]              ce_src;
        logic [PW-1:0]           ce_pin;
        logic [PW-1:0]           oe_pin;
        logic                    oe_act_high;
        force_e                  force_val;
        logic                    cascade;
    } cell_cfg_t;

    localparam int CFGW = $bits(cell_cfg_t);

    function automatic logic pick4(input logic [3:0] v, input logic [1:0] s);
        return v[s];
    endfunction

endpackage

// File: rtl/xp_cfg_store.sv
module xp_cfg_store
    import xp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PW-1:0]    addr,
    input  logic [CFGW-1:0]  wdata,
    input  logic             commit,
    output cell_cfg_t        active [NPINS],
    output logic             valid
);

    cell_cfg_t shadow [NPINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPINS; i++) begin
                shadow[i] <= '0;
                active[i] <= '0;
            end
            valid <= 1'b0;
        end else begin
            if (we) begin
                shadow[addr] <= cell_cfg_t'(wdata);
            end
            if (commit) begin
                for (int i = 0; i < NPINS; i++) begin
                    active[i] <= shadow[i];
                end
                valid <= 1'b1;
            end
        end
    end

    // R2: a commit always leaves the fabric live
    a_r2_commit_sets_valid: assert property (@(posedge clk) disable iff (rst)
        commit |=> valid);

    // R1: nothing but a commit can make the fabric live
    a_r1_no_valid_without_commit: assert property (@(posedge clk) disable iff (rst)
        (!valid && !commit) |=> !valid);

endmodule

// File: rtl/xp_capture.sv
module xp_capture
    import xp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cap_mode_e mode,
    input  logic      d,
    input  logic      rise,
    input  logic      en,
    output logic      q
);

    logic held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
        end else begin
            unique case (mode)
                CAP_LATCH: if (en) held <= d;
                CAP_REG:   if (rise && en) held <= d;
                default:   held <= d;
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            CAP_LATCH: q = en ? d : held;
            CAP_REG:   q = held;
            default:   q = d;
        endcase
    end

    // R6: a closed latch keeps its value
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_LATCH && !en) |=> (mode != CAP_LATCH || en || $stable(q)));

    // R7: a register without a qualified strobe edge keeps its value
    a_r7_reg_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_REG && !(rise && en)) |=> (mode != CAP_REG || $stable(q)));

endmodule

// File: rtl/xp_leg_mux.sv
module xp_leg_mux
    import xp_pkg::*;
(
    input  cell_cfg_t        cfg,
    input  logic [NPINS-1:0] pool,
    output logic             r
);

    logic [NGRP-1:0] legs;
    logic [1:0]      sel;

    always_comb begin
        for (int k = 0; k < NGRP; k++) begin
            legs[k] = pool[{KW'(k), cfg.leg_idx[k]}];
        end
        sel = {pool[cfg.sel_pin[1]], pool[cfg.sel_pin[0]]};
        r   = pick4(legs, sel);
    end

endmodule

// File: rtl/xp_out_cell.sv
module xp_out_cell
    import xp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cell_cfg_t        cfg,
    input  logic             valid,
    input  logic             own_r,
    input  logic [QUAD-1:0]  quad_r,
    input  logic [NPINS-1:0] pool,
    input  logic [NPINS-1:0] pin_in,
    input  logic             rise,
    input  logic             en,
    output logic             dout,
    output logic             oe
);

    logic [1:0] hi_sel;
    logic       path_d;
    logic       cap_q;

    always_comb begin
        hi_sel = {pool[cfg.sel_pin[3]], pool[cfg.sel_pin[2]]};
        path_d = cfg.cascade ? pick4(quad_r, hi_sel) : own_r;
    end

    xp_capture u_out_cap (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg.out_mode),
        .d    (path_d),
        .rise (rise),
        .en   (en),
        .q    (cap_q)
    );

    always_comb begin
        if (!valid) begin
            dout = 1'b0;
        end else begin
            unique case (cfg.force_val)
                FRC_HIGH: dout = 1'b1;
                FRC_LOW:  dout = 1'b0;
                default:  dout = cap_q;
            endcase
        end
        oe = valid && (pin_in[cfg.oe_pin] == cfg.oe_act_high);
    end

endmodule

// File: rtl/xp_crosspoint.sv
module xp_crosspoint
    import xp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [xp_pkg::NPINS-1:0] pin_in,
    input  logic [xp_pkg::NGCLK-1:0] gclk,
    input  logic [xp_pkg::NGCLK-1:0] gce,
    input  logic                     cfg_we,
    input  logic [xp_pkg::PW-1:0]    cfg_addr,
    input  logic [xp_pkg::CFGW-1:0]  cfg_wdata,
    input  logic                     cfg_commit,
    output logic [xp_pkg::NPINS-1:0] pin_out,
    output logic [xp_pkg::NPINS-1:0] pin_oe
);

    cell_cfg_t        act_cfg [NPINS];
    logic             valid;
    logic [NGCLK-1:0] gclk_q;
    logic [NPINS-1:0] pin_q;
    logic [NGCLK-1:0] grise;
    logic [NPINS-1:0] prise;
    logic [NPINS-1:0] cell_rise;
    logic [NPINS-1:0] cell_en;
    logic [NPINS-1:0] pool;
    logic [NPINS-1:0] mux_r;

    xp_cfg_store u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .commit (cfg_commit),
        .active (act_cfg),
        .valid  (valid)
    );

    // Edge detection of every strobe source in the fabric clock
    always_ff @(posedge clk) begin
        if (rst) begin
            gclk_q <= '0;
            pin_q  <= '0;
        end else begin
            gclk_q <= gclk;
            pin_q  <= pin_in;
        end
    end

    assign grise = gclk & ~gclk_q;
    assign prise = pin_in & ~pin_q;

    for (genvar i = 0; i < NPINS; i++) begin : g_cell
        always_comb begin
            if (act_cfg[i].clk_src < SRC_PIN)
                cell_rise[i] = grise[act_cfg[i].clk_src[1:0]];
            else
                cell_rise[i] = prise[act_cfg[i].clk_pin];

            if (act_cfg[i].ce_src < SRC_PIN)
                cell_en[i] = gce[act_cfg[i].ce_src[1:0]];
            else if (act_cfg[i].ce_src == SRC_PIN)
                cell_en[i] = pin_in[act_cfg[i].ce_pin];
            else
                cell_en[i] = 1'b1;
        end

        xp_capture u_in_cap (
            .clk  (clk),
            .rst  (rst),
            .mode (act_cfg[i].in_mode),
            .d    (pin_in[i]),
            .rise (cell_rise[i]),
            .en   (cell_en[i]),
            .q    (pool[i])
        );

        xp_leg_mux u_mux (
            .cfg  (act_cfg[i]),
            .pool (pool),
            .r    (mux_r[i])
        );

        xp_out_cell u_out (
            .clk    (clk),
            .rst    (rst),
            .cfg    (act_cfg[i]),
            .valid  (valid),
            .own_r  (mux_r[i]),
            .quad_r (mux_r[(i/QUAD)*QUAD +: QUAD]),
            .pool   (pool),
            .pin_in (pin_in),
            .rise   (cell_rise[i]),
            .en     (cell_en[i]),
            .dout   (pin_out[i]),
            .oe     (pin_oe[i])
        );
    end

    // R1: reset leaves every output disabled and low
    a_r1_oe_off_after_reset: assert property (@(posedge clk)
        rst |=> (pin_oe == '0));

    a_r1_out_low_after_reset: assert property (@(posedge clk)
        rst |=> (pin_out == '0));

endmodule

// File: tb/xp_crosspoint_tb.sv
module xp_crosspoint_tb;
    import xp_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic [NPINS-1:0] pins;
    logic [NGCLK-1:0] gclk;
    logic [NGCLK-1:0] gce;
    logic             cfg_we;
    logic [PW-1:0]    cfg_addr;
    logic [CFGW-1:0]  cfg_wdata;
    logic             cfg_commit;
    logic [NPINS-1:0] pin_out;
    logic [NPINS-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xp_crosspoint u_dut (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (pins),
        .gclk       (gclk),
        .gce        (gce),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_commit (cfg_commit),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic cell_cfg_t base_cfg();
        cell_cfg_t c;
        c             = '0;
        c.leg_idx[0]  = GW'(1);
        c.sel_pin[0]  = PW'(2);
        c.sel_pin[1]  = PW'(3);
        c.in_mode     = CAP_COMB;
        c.out_mode    = CAP_COMB;
        c.clk_src     = 3'd0;
        c.ce_src      = SRC_ONE;
        c.oe_pin      = PW'(15);
        c.oe_act_high = 1'b1;
        c.force_val   = FRC_NONE;
        return c;
    endfunction

    task automatic write_cfg(input int idx, input cell_cfg_t c);
        cfg_we    = 1'b1;
        cfg_addr  = PW'(idx);
        cfg_wdata = c;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic do_commit();
        cfg_commit = 1'b1;
        tick();
        cfg_commit = 1'b0;
    endtask

    task automatic pulse_g(input int k);
        gclk[k] = 1'b1;
        tick();
        gclk[k] = 1'b0;
        tick();
    endtask

    task automatic pulse_pin(input int k);
        pins[k] = 1'b1;
        tick();
        pins[k] = 1'b0;
        tick();
    endtask

    task automatic t_reset_and_commit();
        cell_cfg_t c;
        chk("R1", "oe after reset", 32'(pin_oe), 32'h0);
        chk("R1", "out after reset", 32'(pin_out), 32'h0);
        c = base_cfg();
        write_cfg(5, c);
        tick();
        chk("R2", "oe before commit", 32'(pin_oe[5]), 32'h0);
        chk("R1", "out before commit", 32'(pin_out), 32'h0);
        pins[1] = 1'b1;
        do_commit();
        chk("R2", "oe after commit", 32'(pin_oe[5]), 32'h1);
        chk("R2", "out after commit", 32'(pin_out[5]), 32'h1);
        c.force_val = FRC_LOW;
        write_cfg(5, c);
        tick();
        chk("R2", "uncommitted force ignored", 32'(pin_out[5]), 32'h1);
        c.force_val = FRC_NONE;
        write_cfg(5, c);
        do_commit();
    endtask

    task automatic t_leg_mux();
        cell_cfg_t c;
        logic [1:0] lsel [4];
        lsel[0] = 2'd1; lsel[1] = 2'd2; lsel[2] = 2'd3; lsel[3] = 2'd0;
        c = base_cfg();
        for (int k = 0; k < 4; k++) c.leg_idx[k] = lsel[k];
        write_cfg(5, c);
        do_commit();
        for (int n = 0; n < 20; n++) begin
            logic [1:0] s;
            int src;
            pins     = NPINS'($urandom);
            pins[15] = 1'b1;
            #1;
            s   = {pins[3], pins[2]};
            src = int'(s) * GSIZE + int'(lsel[s]);
            chk("R3", "leg mux", 32'(pin_out[5]), 32'(pins[src]));
        end
        pins = 16'h8000;
        #1;
        chk("R5", "comb low", 32'(pin_out[5]), 32'h0);
        pins[1] = 1'b1;
        #1;
        chk("R5", "comb same cycle", 32'(pin_out[5]), 32'h1);
    endtask

    task automatic t_oe_polarity();
        cell_cfg_t c;
        c = base_cfg();
        c.oe_pin      = PW'(14);
        c.oe_act_high = 1'b0;
        write_cfg(5, c);
        do_commit();
        pins[14] = 1'b1;
        #1;
        chk("R10", "active low, pin high", 32'(pin_oe[5]), 32'h0);
        pins[14] = 1'b0;
        #1;
        chk("R10", "active low, pin low", 32'(pin_oe[5]), 32'h1);
        c.oe_act_high = 1'b1;
        write_cfg(5, c);
        do_commit();
        chk("R10", "active high, pin low", 32'(pin_oe[5]), 32'h0);
        pins[14] = 1'b1;
        #1;
        chk("R10", "active high, pin high", 32'(pin_oe[5]), 32'h1);
    endtask

    task automatic t_force();
        cell_cfg_t c;
        c = base_cfg();
        c.force_val = FRC_HIGH;
        write_cfg(5, c);
        pins[1] = 1'b0;
        do_commit();
        chk("R11", "force high over 0", 32'(pin_out[5]), 32'h1);
        c.force_val = FRC_LOW;
        write_cfg(5, c);
        pins[1] = 1'b1;
        do_commit();
        chk("R11", "force low over 1", 32'(pin_out[5]), 32'h0);
        pins[1] = 1'b0;
        #1;
        pins[1] = 1'b1;
        #1;
        chk("R11", "force low steady", 32'(pin_out[5]), 32'h0);
    endtask

    task automatic t_latch();
        cell_cfg_t c;
        c = base_cfg();
        c.out_mode = CAP_LATCH;
        c.ce_src   = 3'd0;
        write_cfg(5, c);
        gce[0]  = 1'b1;
        pins[1] = 1'b1;
        do_commit();
        chk("R6", "latch open 1", 32'(pin_out[5]), 32'h1);
        pins[1] = 1'b0;
        #1;
        chk("R6", "latch open follows", 32'(pin_out[5]), 32'h0);
        tick();
        gce[0] = 1'b0;
        tick();
        pins[1] = 1'b1;
        #1;
        chk("R6", "latch closed holds", 32'(pin_out[5]), 32'h0);
        tick();
        tick();
        chk("R6", "latch closed later", 32'(pin_out[5]), 32'h0);
        gce[0] = 1'b1;
        #1;
        chk("R6", "latch reopened", 32'(pin_out[5]), 32'h1);
    endtask

    task automatic t_register();
        cell_cfg_t c;
        c = base_cfg();
        c.out_mode = CAP_REG;
        c.clk_src  = 3'd1;
        pins[1]    = 1'b0;
        tick();
        write_cfg(5, c);
        do_commit();
        pins[1] = 1'b1;
        tick();
        tick();
        chk("R7", "no strobe holds", 32'(pin_out[5]), 32'h0);
        gclk[1] = 1'b1;
        tick();
        chk("R7", "strobe loads", 32'(pin_out[5]), 32'h1);
        gclk[1] = 1'b0;
        pins[1] = 1'b0;
        tick();
        chk("R7", "holds after strobe", 32'(pin_out[5]), 32'h1);
        pulse_g(0);
        chk("R8", "other global ignored", 32'(pin_out[5]), 32'h1);
        c.clk_src = SRC_PIN;
        c.clk_pin = PW'(9);
        write_cfg(5, c);
        do_commit();
        pulse_pin(9);
        chk("R8", "pin strobe loads", 32'(pin_out[5]), 32'h0);
        c.ce_src = SRC_PIN;
        c.ce_pin = PW'(13);
        write_cfg(5, c);
        pins[13] = 1'b0;
        do_commit();
        pins[1] = 1'b1;
        pulse_pin(9);
        chk("R7", "enable low blocks", 32'(pin_out[5]), 32'h0);
        pins[13] = 1'b1;
        pulse_pin(9);
        chk("R8", "pin enable allows", 32'(pin_out[5]), 32'h1);
        pins[13] = 1'b0;
    endtask

    task automatic t_input_capture();
        cell_cfg_t c1;
        cell_cfg_t c5;
        c5 = base_cfg();
        c1 = base_cfg();
        c1.in_mode = CAP_REG;
        c1.clk_src = 3'd2;
        pins[1] = 1'b0;
        write_cfg(5, c5);
        write_cfg(1, c1);
        do_commit();
        pins[1] = 1'b1;
        tick();
        chk("R9", "input reg holds", 32'(pin_out[5]), 32'h0);
        pulse_g(2);
        chk("R9", "input reg loads", 32'(pin_out[5]), 32'h1);
        // same strobe on both stages
        c5.out_mode = CAP_REG;
        c5.clk_src  = 3'd2;
        write_cfg(5, c5);
        do_commit();
        pins[1] = 1'b0;
        pulse_g(2);
        chk("R9", "shared strobe first pulse", 32'(pin_out[5]), 32'h1);
        pulse_g(2);
        chk("R7", "shared strobe second pulse", 32'(pin_out[5]), 32'h0);
        pins[1] = 1'b1;
        pulse_g(2);
        chk("R9", "shared strobe rise first", 32'(pin_out[5]), 32'h0);
        pulse_g(2);
        chk("R7", "shared strobe rise second", 32'(pin_out[5]), 32'h1);
        write_cfg(1, base_cfg());
        write_cfg(5, base_cfg());
        do_commit();
    endtask

    task automatic t_cascade();
        cell_cfg_t c;
        for (int m = 4; m < 8; m++) begin
            c = base_cfg();
            for (int k = 0; k < 4; k++) c.leg_idx[k] = GW'((m + k) % 4);
            if (m == 5) begin
                c.cascade    = 1'b1;
                c.sel_pin[2] = PW'(0);
                c.sel_pin[3] = PW'(10);
            end
            write_cfg(m, c);
        end
        do_commit();
        for (int n = 0; n < 32; n++) begin
            int hi;
            int lo;
            int src;
            pins     = NPINS'($urandom);
            pins[15] = 1'b1;
            #1;
            hi  = int'({pins[10], pins[0]});
            lo  = int'({pins[3], pins[2]});
            src = lo * GSIZE + ((4 + hi + lo) % 4);
            chk("R4", "cascade 16:1", 32'(pin_out[5]), 32'(pins[src]));
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        pins       = 16'h8000;
        gclk       = '0;
        gce        = '0;
        cfg_we     = 1'b0;
        cfg_addr   = '0;
        cfg_wdata  = '0;
        cfg_commit = 1'b0;
        tick();
        tick();
        tick();
        rst = 1'b0;
        tick();
        t_reset_and_commit();
        t_leg_mux();
        pins = 16'h8000;
        t_oe_polarity();
        pins = 16'h8000;
        t_force();
        pins = 16'h8000;
        t_latch();
        pins = 16'h8000;
        gce  = '0;
        t_register();
        pins = 16'h8000;
        t_input_capture();
        t_cascade();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule